// File: doc/BRIEF.md
# Latched Event Interrupt Register Pair

This block gathers the interrupt events raised by a device's own function logic. Each of up to 32 source lines is watched for a rising edge. An edge sets a sticky bit in an event register. Software reaches the block over a simple 32-bit register bus and can flip any event bit, which both acknowledges events and lets it inject test interrupts. A second register holds one mask bit per source. The block reduces the masked events to a single request line, and that line feeds one input of the device-level interrupt aggregator.

The event register sits at byte address 32 and the mask register at byte address 40. Reads are combinational on the address. Writes take effect at the next clock edge. Priority encoding and any global gating are done further up the hierarchy.

The reset input is asynchronous and active low. It is released to the registers through a two-flop synchronizer, so the registers leave reset on the second clock edge after the input rises.

Top module: `ip_event_irq`

## Requirements
- R1: After reset the event register and the mask register both read zero and `irq_out` is low.
- R2: A 0-to-1 transition on `src_in[i]` sets event bit i at the clock edge that samples the new level. A source held high sets the bit only once: after software clears the bit, it stays clear until the source falls and rises again.
- R3: An event bit that is set stays set until a software write changes it, whatever its source does.
- R4: A write to byte address 32 inverts each event bit whose write-data bit is 1 and leaves the other bits unchanged. Writing 1 to a clear bit therefore sets it.
- R5: Events are captured whatever the value of the mask register.
- R6: A write to byte address 40 replaces the mask register with the write data, and reading address 40 returns it.
- R7: `irq_out` is 1 exactly when some bit i has both event bit i and mask bit i set.
- R8: When a rising edge on source i and a write to address 32 with data bit i = 1 meet at the same clock edge, event bit i ends set.
- R9: Read-data bits at and above N are zero and write-data bits there are ignored. Reads of any address other than 32 or 40 return zero, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_in | input | N | Event source lines, edge-sensitive |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | OR of the event bits masked by the mask bits |

## Verification
The bound assertions check on every cycle that each detected edge lands in the event register, that set bits persist without a write, that a toggle write with no coincident edge flips exactly the written bits, that mask writes load the mask, that the request line is low whenever nothing masked is pending, and that unused read bits stay zero. A cycle-by-cycle model in the bench carries those same rules across long sequences. Directed scenarios cover the cases a single-step property cannot show: a source held high not setting its bit again after it is cleared, an edge and a toggle meeting on the same bit both from clear and from set, writes to unmapped addresses and to upper bits being ignored, and software injection of an interrupt.

// File: rtl/ip_event_pkg.sv
package ip_event_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned EVT_OFFSET = 32;
  localparam int unsigned MSK_OFFSET = 40;
endpackage

// File: rtl/ip_event_rst_sync.sv
module ip_event_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ip_event_edge.sv
module ip_event_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_in;
  end

  assign rise = src_in & ~prev_q;
endmodule

// File: rtl/ip_event_status.sv
module ip_event_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog_wr,
  input  logic [N-1:0] tog_data,
  input  logic [N-1:0] rise,
  output logic [N-1:0] evt_q
);
  logic [N-1:0] evt_d;
  logic         evt_en;

  // A toggle is applied first; a coincident edge then wins (set dominates).
  always_comb begin
    evt_d  = evt_q;
    if (tog_wr) evt_d = evt_d ^ tog_data;
    evt_d  = evt_d | rise;
    evt_en = tog_wr | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end
endmodule

// File: rtl/ip_event_enable.sv
module ip_event_enable #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_wr,
  input  logic [N-1:0] ld_data,
  output logic [N-1:0] msk_q
);
  logic [N-1:0] msk_d;

  always_comb msk_d = ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     msk_q <= '0;
    else if (ld_wr) msk_q <= msk_d;
  end
endmodule

// File: rtl/ip_event_irq.sv
module ip_event_irq
  import ip_event_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(EVT_OFFSET);
  localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(MSK_OFFSET);

  logic         rst_sync_n;
  logic [N-1:0] rise;
  logic [N-1:0] evt_q;
  logic [N-1:0] msk_q;
  logic         hit_evt;
  logic         hit_msk;

  initial begin
    if (N < 1 || N > BUS_W) $error("N must be 1..32");
  end

  assign hit_evt = (bus_addr == EVT_ADDR);
  assign hit_msk = (bus_addr == MSK_ADDR);

  ip_event_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ip_event_edge #(.N(N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_in (src_in),
    .rise   (rise)
  );

  ip_event_status #(.N(N)) u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tog_wr   (bus_wr & hit_evt),
    .tog_data (bus_wdata[N-1:0]),
    .rise     (rise),
    .evt_q    (evt_q)
  );

  ip_event_enable #(.N(N)) u_msk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_wr   (bus_wr & hit_msk),
    .ld_data (bus_wdata[N-1:0]),
    .msk_q   (msk_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_evt)      bus_rdata[N-1:0] = evt_q;
    else if (hit_msk) bus_rdata[N-1:0] = msk_q;
  end

  assign irq_out = |(evt_q & msk_q);
endmodule

// File: rtl/ip_event_irq_chk.sv
module ip_event_irq_chk
  import ip_event_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      src_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq_out,
  input logic [N-1:0]      evt_q,
  input logic [N-1:0]      msk_q
);
  localparam logic [BUS_W-1:0] LIVE = (N >= BUS_W) ? '1 : ((BUS_W'(1) << N) - 1);

  logic [N-1:0] seen_q;
  logic [N-1:0] edge_now;
  logic         evt_wr;
  logic         msk_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= src_in;
  end

  assign edge_now = src_in & ~seen_q;
  assign evt_wr   = bus_wr && (bus_addr == ADDR_W'(EVT_OFFSET));
  assign msk_wr   = bus_wr && (bus_addr == ADDR_W'(MSK_OFFSET));

  // R2, R5, R8: every detected edge is present in the event register next cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_now) |=> ((evt_q & $past(edge_now)) == $past(edge_now)));

  // R3: without an event write, no set bit drops
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_wr) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R4: toggle write with no coincident edge flips exactly the written bits
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && edge_now == '0) |=> (evt_q == $past(evt_q ^ bus_wdata[N-1:0])));

  // R6: mask write loads the mask
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr |=> (msk_q == $past(bus_wdata[N-1:0])));

  // R7: nothing pending under the mask means no request
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & msk_q) == '0) |-> !irq_out);

  // R9: unused read-data bits stay zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~LIVE) == '0));
endmodule

bind ip_event_irq ip_event_irq_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_in    (src_in),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .evt_q     (evt_q),
  .msk_q     (msk_q)
);

// File: tb/ip_event_irq_test.sv
`timescale 1ns/1ps
module ip_event_irq_test;
  localparam int N  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int unsigned m_evt  = 0;
  int unsigned m_msk  = 0;
  int unsigned m_prev = 0;
  int unsigned mask_n = (1 << N) - 1;

  always #2.5 clk = ~clk;

  ip_event_irq #(.N(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model update at each edge, compare just after it
  always @(posedge clk) begin
    if (!rst_n) begin
      m_evt = 0; m_msk = 0; m_prev = 0;
    end else begin
      int unsigned rise;
      rise = int'(src_in) & ~m_prev & mask_n;
      if (bus_wr && bus_addr == 8'd32) m_evt = m_evt ^ (bus_wdata & mask_n);
      if (bus_wr && bus_addr == 8'd40) m_msk = bus_wdata & mask_n;
      m_evt  = m_evt | rise;
      m_prev = int'(src_in);
    end
    #1;
    chk("R7 irq_out vs model", {31'd0, irq_out}, {31'd0, ((m_evt & m_msk) != 0)});
    if (bus_addr == 8'd32)      chk("R3 event read vs model", bus_rdata, m_evt);
    else if (bus_addr == 8'd40) chk("R6 mask read vs model", bus_rdata, m_msk);
    else                        chk("R9 unmapped read vs model", bus_rdata, 32'd0);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd(8'd32, 32'h0, "R1 event after reset");
    rd(8'd40, 32'h0, "R1 mask after reset");
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);

    // R2/R5 single pulse captured with mask clear
    src_in = 8'h04; @(negedge clk); src_in = '0;
    rd(8'd32, 32'h04, "R2 pulse captured");
    chk("R5 no irq while masked", {31'd0, irq_out}, 32'd0);
    idle(3);
    rd(8'd32, 32'h04, "R3 bit persists");

    // R2 held level: clear while high, no re-set
    wr(8'd32, 32'h04);
    rd(8'd32, 32'h00, "R4 toggle clears");
    src_in = 8'h04; @(negedge clk);
    rd(8'd32, 32'h04, "R2 level rise captured");
    wr(8'd32, 32'h04);
    idle(3);
    rd(8'd32, 32'h00, "R2 held level does not re-set");
    src_in = '0; idle(1);

    // R4/R7 software injection and masking
    wr(8'd40, 32'h04);
    chk("R7 irq low with nothing pending", {31'd0, irq_out}, 32'd0);
    wr(8'd32, 32'h04);
    rd(8'd32, 32'h04, "R4 forced bit");
    chk("R7 irq high when masked bit set", {31'd0, irq_out}, 32'd1);
    wr(8'd40, 32'h02);
    chk("R7 irq low when mask cleared", {31'd0, irq_out}, 32'd0);

    // R9 upper bits and unmapped addresses
    wr(8'd40, 32'hFFFF_FFFF);
    rd(8'd40, 32'h0000_00FF, "R9 mask upper bits dropped");
    wr(8'd32, 32'hFFFF_FF00);
    rd(8'd32, 32'h04, "R9 event upper bits ignored");
    wr(8'd36, 32'hFFFF_FFFF);
    rd(8'd36, 32'h0, "R9 unmapped reads zero");
    rd(8'd32, 32'h04, "R9 unmapped write left event");
    rd(8'd40, 32'hFF, "R9 unmapped write left mask");

    // R8 edge and toggle together, bit clear then bit set
    src_in = 8'h20; wr(8'd32, 32'h20); src_in = '0;
    rd(8'd32, 32'h24, "R8 coincident from clear");
    idle(1);
    src_in = 8'h20; wr(8'd32, 32'h20); src_in = '0;
    rd(8'd32, 32'h24, "R8 coincident from set");

    // multi-source pattern, then clear all
    src_in = 8'h81; @(negedge clk); src_in = 8'h18; @(negedge clk); src_in = '0;
    rd(8'd32, 32'hBD, "R2 multiple sources");
    wr(8'd32, 32'hBD);
    rd(8'd32, 32'h00, "R4 clear all");
    chk("R7 irq low after clear", {31'd0, irq_out}, 32'd0);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule